// File: doc/BRIEF.md
# Source-Initiated Four-Phase Handshake Link

This block holds both ends of a parallel word link that needs no shared timing between its ends. The sending half takes a word from a local request/ready port. It puts the word on its outgoing data bus, and one cycle later raises its valid line. It then waits for the far side's accept line, which it samples through two flops. Once accept is seen, it drops valid. It returns to idle only after accept has gone low again.

The receiving half samples the incoming valid line through two flops. It copies the incoming bus into a one-word output slot, but only when that slot is empty. At the same time it raises accept. When it sees valid fall, it drops accept. Each step may take any number of cycles, so the slower half sets the rate of the link.

Each half has a wait counter. If a partner leaves a half waiting for a fixed number of cycles, that half sets a sticky error flag and returns to idle. In use, the link outputs of one instance are wired to the link inputs of a second instance, which may run on another clock. A loopback between the two halves of a single instance also works.

Top module: `hs_link`

## Requirements
- R1: While reset is held, `lnk_valid_o`, `lnk_acc_o`, `rcv_vld`, `snd_err` and `rcv_err` are 0 and `snd_rdy` is 1.
- R2: `snd_rdy` is 1 only when the sender is idle and its synchronized accept is 0. A word is taken on a clock edge where `snd_req` and `snd_rdy` are both 1.
- R3: A taken word appears on `lnk_data_o` one cycle before `lnk_valid_o` rises. The word stays unchanged while `lnk_valid_o` is 1.
- R4: When the synchronized valid is 1, the receiver is idle and armed, and the output slot is empty, the receiver copies `lnk_data_i` into `rcv_word` and raises `lnk_acc_o` on the same edge. Words arrive in the order they were sent.
- R5: The sender drops `lnk_valid_o` on the edge after its synchronized accept reads 1. It becomes ready again once the synchronized accept reads 0.
- R6: The receiver drops `lnk_acc_o` on the edge after its synchronized valid reads 0.
- R7: `rcv_vld` stays 1 with `rcv_word` unchanged until a cycle with `rcv_take` = 1. While the slot is full, no new word is accepted, and the sender keeps waiting.
- R8: Each incoming control line passes through two flops. From the cycle `lnk_valid_o` rises on a loopback, `lnk_acc_o` rises 3 cycles later. From the rise of `lnk_acc_o`, `lnk_valid_o` falls 3 cycles later.
- R9: If the sender spends TMO cycles in one waiting phase without the expected accept change, it sets `snd_err`, drops `lnk_valid_o` and returns to idle.
- R10: If the receiver holds `lnk_acc_o` for TMO cycles while valid stays high, it sets `rcv_err`, drops `lnk_acc_o` and returns to idle.
- R11: `snd_err` and `rcv_err` stay 1 until reset, even while later transfers complete.
- R12: After accepting a word, the receiver accepts no new word until it has seen its synchronized valid at 0. A valid stuck high after a receiver timeout therefore causes no second capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_req | input | 1 | Local request to send `snd_word` |
| snd_word | input | W | Word to send |
| snd_rdy | output | 1 | Sender can take a word this cycle |
| snd_err | output | 1 | Sticky sender timeout flag |
| lnk_data_o | output | W | Outgoing link data bus |
| lnk_valid_o | output | 1 | Outgoing data-valid |
| lnk_acc_i | input | 1 | Incoming data-accepted (unsynchronized) |
| lnk_data_i | input | W | Incoming link data bus |
| lnk_valid_i | input | 1 | Incoming data-valid (unsynchronized) |
| lnk_acc_o | output | 1 | Outgoing data-accepted |
| rcv_vld | output | 1 | Output slot holds a received word |
| rcv_word | output | W | Received word |
| rcv_take | input | 1 | Local consumer empties the slot |
| rcv_err | output | 1 | Sticky receiver timeout flag |

## Verification
The link is run as a loopback under several stimulus patterns:
- **Back-to-back requests with an eager consumer.** This shows the full return-to-idle timing and the three-cycle synchronizer latencies.
- **A held-off consumer.** This separates correct back-pressure, where the sender is left waiting with valid high, from overwriting the slot.
- **A cut accept path.** This drives the sender into its timeout.
- **A valid line forced high, and a stuck-high accept line.** The forced valid drives the receiver into its timeout and shows that no duplicate capture happens. The stuck accept shows that the sender withholds ready while accept is high.

// File: rtl/hs_link.sv
module hs_link #(
  parameter int W   = 8,
  parameter int TMO = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snd_req,
  input  logic [W-1:0] snd_word,
  output logic         snd_rdy,
  output logic         snd_err,
  output logic [W-1:0] lnk_data_o,
  output logic         lnk_valid_o,
  input  logic         lnk_acc_i,
  input  logic [W-1:0] lnk_data_i,
  input  logic         lnk_valid_i,
  output logic         lnk_acc_o,
  output logic         rcv_vld,
  output logic [W-1:0] rcv_word,
  input  logic         rcv_take,
  output logic         rcv_err
);

  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_WAIT_ACC, S_WAIT_REL} snd_st_t;

  // two-flop synchronizers on incoming control lines
  logic acc_m, acc_s, val_m, val_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_m <= 1'b0; acc_s <= 1'b0; val_m <= 1'b0; val_s <= 1'b0;
    end else begin
      acc_m <= lnk_acc_i; acc_s <= acc_m;
      val_m <= lnk_valid_i; val_s <= val_m;
    end

  // sender
  snd_st_t        s_st;
  logic [CW-1:0]  s_cnt;
  logic [W-1:0]   s_data;

  wire s_wait = (s_st == S_WAIT_ACC) || (s_st == S_WAIT_REL);
  wire s_step = ((s_st == S_WAIT_ACC) && acc_s) || ((s_st == S_WAIT_REL) && !acc_s);
  wire s_tmo  = s_wait && !s_step && (s_cnt == LAST);

  assign snd_rdy     = (s_st == S_IDLE) && !acc_s;
  assign lnk_valid_o = (s_st == S_WAIT_ACC);
  assign lnk_data_o  = s_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_st   <= S_IDLE;
      s_data <= '0;
      s_err_q <= 1'b0;
    end else begin
      if (s_tmo) s_err_q <= 1'b1;
      case (s_st)
        S_IDLE:     if (snd_req && snd_rdy) begin s_data <= snd_word; s_st <= S_SETUP; end
        S_SETUP:    s_st <= S_WAIT_ACC;
        S_WAIT_ACC: if (acc_s) s_st <= S_WAIT_REL; else if (s_tmo) s_st <= S_IDLE;
        S_WAIT_REL: if (!acc_s || s_tmo) s_st <= S_IDLE;
        default:    s_st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                s_cnt <= '0;
    else if (!s_wait || s_step || s_tmo) s_cnt <= '0;
    else                       s_cnt <= s_cnt + 1'b1;

  logic s_err_q;
  assign snd_err = s_err_q;

  // receiver
  logic          r_ack, r_armed, r_full, r_err_q;
  logic [CW-1:0] r_cnt;
  logic [W-1:0]  r_word;

  wire r_latch = !r_ack && val_s && r_armed && !r_full;
  wire r_tmo   = r_ack && val_s && (r_cnt == LAST);

  assign lnk_acc_o = r_ack;
  assign rcv_vld   = r_full;
  assign rcv_word  = r_word;
  assign rcv_err   = r_err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_ack <= 1'b0; r_armed <= 1'b1; r_full <= 1'b0; r_err_q <= 1'b0; r_word <= '0;
    end else begin
      if (r_latch) begin
        r_word  <= lnk_data_i;
        r_full  <= 1'b1;
        r_ack   <= 1'b1;
        r_armed <= 1'b0;
      end else begin
        if (rcv_take) r_full <= 1'b0;
        if (!val_s) r_armed <= 1'b1;
        if (r_ack && (!val_s || r_tmo)) r_ack <= 1'b0;
      end
      if (r_tmo) r_err_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      r_cnt <= '0;
    else if (!r_ack || !val_s || r_tmo) r_cnt <= '0;
    else                             r_cnt <= r_cnt + 1'b1;

  AST_RDY_ACC_LOW: assert property (@(posedge clk) disable iff (!rst_n) snd_rdy |-> !$past(lnk_acc_i, 2)); // R2
  AST_SETUP_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(lnk_valid_o) |-> $stable(lnk_data_o)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) lnk_valid_o && $past(lnk_valid_o) |-> $stable(lnk_data_o)); // R3
  AST_VALID_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(lnk_valid_o) |-> $past(lnk_acc_i, 3) || snd_err); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rcv_vld && !rcv_take |=> rcv_vld && $stable(rcv_word)); // R7
  AST_ACC_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $rose(lnk_acc_o) |-> $past(lnk_valid_i, 3)); // R8
  AST_SND_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) snd_err |=> snd_err); // R11
  AST_RCV_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rcv_err |=> rcv_err); // R11

endmodule

// File: tb/sim_hs_link.sv
module sim_hs_link;
  localparam int CLK_NS = 10;
  localparam int W = 8;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snd_req = 1'b0, rcv_take = 1'b1;
  logic [W-1:0] snd_word = '0;
  logic snd_rdy, snd_err, lnk_valid_o, lnk_acc_o, rcv_vld, rcv_err;
  logic [W-1:0] lnk_data_o, rcv_word;
  logic cut_acc = 1'b0, f_acc = 1'b0, cut_val = 1'b0, f_val = 1'b0;
  logic [W-1:0] f_data = '0;
  logic link_acc, link_val;
  logic [W-1:0] link_data;
  assign link_acc  = cut_acc ? f_acc : lnk_acc_o;
  assign link_val  = cut_val ? f_val : lnk_valid_o;
  assign link_data = cut_val ? f_data : lnk_data_o;

  always #(CLK_NS/2) clk = ~clk;

  hs_link #(.W(W), .TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_word(snd_word), .snd_rdy(snd_rdy),
    .snd_err(snd_err), .lnk_data_o(lnk_data_o), .lnk_valid_o(lnk_valid_o), .lnk_acc_i(link_acc),
    .lnk_data_i(link_data), .lnk_valid_i(link_val), .lnk_acc_o(lnk_acc_o), .rcv_vld(rcv_vld),
    .rcv_word(rcv_word), .rcv_take(rcv_take), .rcv_err(rcv_err));

  int n_chk = 0, n_err = 0;
  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped on pre-edge values
  int m_sst, m_scnt, m_rst, m_rcnt;
  bit m_a1, m_a2, m_v1, m_v2, m_armed, m_full, m_serr, m_rerr;
  logic [W-1:0] m_sdata, m_rword;
  logic [W-1:0] sent_q[$];
  bit sb_on = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sst = 0; m_scnt = 0; m_rst = 0; m_rcnt = 0;
      m_a1 = 0; m_a2 = 0; m_v1 = 0; m_v2 = 0;
      m_armed = 1; m_full = 0; m_serr = 0; m_rerr = 0;
      m_sdata = '0; m_rword = '0;
      sent_q.delete();
    end else begin
      bit a_s, v_s;
      a_s = m_a2; v_s = m_v2;
      if (sb_on && rcv_vld && rcv_take) begin
        if (sent_q.size() == 0) chk("R4", "unexpected word", rcv_word, 32'hFFFF);
        else chk("R4", "word order", rcv_word, sent_q.pop_front());
      end
      case (m_sst)
        0: if (snd_req && !a_s) begin m_sdata = snd_word; m_sst = 1; if (sb_on) sent_q.push_back(snd_word); end
        1: begin m_sst = 2; m_scnt = 0; end
        2: if (a_s) begin m_sst = 3; m_scnt = 0; end
           else if (m_scnt == TMO-1) begin m_serr = 1; m_sst = 0; m_scnt = 0; end
           else m_scnt++;
        default: if (!a_s) begin m_sst = 0; m_scnt = 0; end
           else if (m_scnt == TMO-1) begin m_serr = 1; m_sst = 0; m_scnt = 0; end
           else m_scnt++;
      endcase
      if (m_rst == 0 && v_s && m_armed && !m_full) begin
        m_rword = link_data; m_full = 1; m_rst = 1; m_armed = 0; m_rcnt = 0;
      end else begin
        if (rcv_take) m_full = 0;
        if (!v_s) m_armed = 1;
        if (m_rst == 1) begin
          if (!v_s) begin m_rst = 0; m_rcnt = 0; end
          else if (m_rcnt == TMO-1) begin m_rerr = 1; m_rst = 0; m_rcnt = 0; end
          else m_rcnt++;
        end
      end
      m_a2 = m_a1; m_a1 = link_acc; m_v2 = m_v1; m_v1 = link_val;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R3", "lnk_valid_o", lnk_valid_o, m_sst == 2);
    chk("R3", "lnk_data_o", lnk_data_o, m_sdata);
    chk("R2", "snd_rdy", snd_rdy, m_sst == 0 && !m_a2);
    chk("R4", "lnk_acc_o", lnk_acc_o, m_rst == 1);
    chk("R7", "rcv_vld", rcv_vld, m_full);
    chk("R4", "rcv_word", rcv_word, m_rword);
    chk("R9", "snd_err", snd_err, m_serr);
    chk("R10", "rcv_err", rcv_err, m_rerr);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(logic [W-1:0] w);
    @(negedge clk); #1;
    snd_req = 1'b1; snd_word = w;
    @(posedge clk);
    while (!snd_rdy) @(posedge clk);
    @(negedge clk); #1;
    snd_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int t0, t1, hits;
    cyc(2);
    chk("R1", "valid in reset", lnk_valid_o, 0);
    chk("R1", "acc in reset", lnk_acc_o, 0);
    chk("R1", "rcv_vld in reset", rcv_vld, 0);
    chk("R1", "errors in reset", {snd_err, rcv_err}, 0);
    chk("R1", "rdy in reset", snd_rdy, 1);
    rst_n = 1'b1;
    cyc(2);

    // R8 latencies on first transfer
    fork
      send(8'h5A);
      begin
        t0 = 0;
        while (!lnk_valid_o) begin @(negedge clk); end
        while (!lnk_acc_o) begin @(negedge clk); t0++; end
        t1 = 0;
        while (lnk_valid_o) begin @(negedge clk); t1++; end
        chk("R8", "valid to acc cycles", t0, 3);
        chk("R8", "acc to valid fall cycles", t1, 3);
      end
    join
    cyc(12);
    chk("R6", "acc back low", lnk_acc_o, 0);
    chk("R5", "sender ready again", snd_rdy, 1);

    // back-to-back, eager consumer
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i * 7));
    cyc(20);

    // held-off consumer: pacing by the slower side
    rcv_take = 1'b0;
    send(8'hA1);
    cyc(14);
    send(8'hB2);
    cyc(6);
    chk("R7", "slot held", rcv_word, 8'hA1);
    chk("R7", "no accept while full", lnk_acc_o, 0);
    chk("R7", "sender still waiting", lnk_valid_o, 1);
    rcv_take = 1'b1;
    cyc(20);
    chk("R7", "second word delivered", sent_q.size(), 0);

    // sender timeout with accept path cut
    cut_acc = 1'b1; f_acc = 1'b0;
    send(8'hC3);
    cyc(TMO + 10);
    chk("R9", "snd_err set", snd_err, 1);
    chk("R9", "valid dropped", lnk_valid_o, 0);
    cut_acc = 1'b0;
    cyc(4);
    send(8'hD4);
    cyc(20);
    chk("R11", "snd_err still set", snd_err, 1);

    do_reset();
    cyc(1);
    chk("R11", "reset clears errors", {snd_err, rcv_err}, 0);

    // receiver timeout with valid stuck high
    sb_on = 1'b0;
    cut_val = 1'b1; f_val = 1'b1; f_data = 8'hE5;
    cyc(TMO + 10);
    chk("R10", "rcv_err set", rcv_err, 1);
    chk("R10", "acc dropped", lnk_acc_o, 0);
    hits = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (lnk_acc_o) hits++; end
    chk("R12", "no recapture while valid high", hits, 0);
    f_val = 1'b0;
    cyc(4);
    f_data = 8'h6E; f_val = 1'b1;
    cyc(5);
    chk("R12", "rearmed capture acc", lnk_acc_o, 1);
    chk("R12", "rearmed capture word", rcv_word, 8'h6E);
    f_val = 1'b0;
    cyc(6);
    cut_val = 1'b0;
    cyc(4);

    // accept stuck high while idle
    cut_acc = 1'b1; f_acc = 1'b1;
    cyc(4);
    chk("R2", "not ready with accept high", snd_rdy, 0);
    f_acc = 1'b0;
    cyc(4);
    chk("R2", "ready once accept low", snd_rdy, 1);
    cut_acc = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule